// File: doc/BRIEF.md
# Byte-Addressed Word Memory Adapter

This block connects a requester that speaks in byte addresses to an 8 KiB synchronous memory organised as 32-bit words. Each request carries a byte address, a size code, a write flag and write data. The block discards the two low address bits to pick a word. It turns the low bits and the size into a per-lane write strobe and moves the write data onto the lanes it targets. A read always fetches the whole word. The adapter then moves the requested bytes down to bit 0 and clears every bit above them.

Each request is answered exactly one clock later. The response carries an error flag for three cases: an unknown size code, a misaligned halfword or word, and an address beyond the 8 KiB window. A misaligned or badly sized request is refused outright. An out-of-range address is still served, at the location found by masking the address with 0x1FFF, and its error flag is raised.

Top module: `laneMemAdapter`

## Requirements
- R1: The memory is little endian. The byte at offset o sits in data bits [8*(o mod 4)+7 : 8*(o mod 4)] of word o[12:2]. A word written at offset 4k is read back unchanged as a word at 4k.
- R2: A write changes only the lanes its size and address select: one lane for a byte, two for a halfword, four for a word. The requester supplies the write value in the low bits of reqWdata, and the bits above the access size are ignored. Bytes outside the access keep their previous value.
- R3: A read returns the addressed bytes in the low bits, zero-extended: 8 bits for a byte, 16 for a halfword and 32 for a word. The whole word is fetched, and the lanes that are not used are discarded.
- R4: rspValid is high in the clock after a cycle with reqValid high, and low otherwise. While rspValid is low, rspRdata and rspErr are zero. A write response returns rspRdata zero.
- R5: reqSize is 2'b00 for a byte, 2'b01 for a halfword and 2'b10 for a word. The code 2'b11 gives rspErr=1 and rspRdata=0, and does not write.
- R6: A halfword with address bit 0 set, or a word with address bits [1:0] nonzero, gives rspErr=1 and rspRdata=0, and changes no memory byte.
- R7: 0x1FFF is the last error-free start for a byte, 0x1FFE for a halfword and 0x1FFC for a word. Each of these completes with rspErr=0.
- R8: An aligned request with any address bit above bit 12 set gives rspErr=1. It is still carried out at offset (address & 0x1FFF), so a word write to 0x2000 lands at 0x0000.
- R9: After reset, rspValid, rspErr and rspRdata are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is presented this cycle |
| reqAddr | input | 16 | Byte address |
| reqSize | input | 2 | Access size code |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqWdata | input | 32 | Write value in the low bits |
| rspValid | output | 1 | Response for the previous cycle's request |
| rspRdata | output | 32 | Zero-extended read result |
| rspErr | output | 1 | Misaligned, bad size or out-of-range request |

## Verification
The bench fills the whole memory with words and reads every byte, every aligned halfword and every word back. A lane swap, an off-by-one word index or a missing zero extension would therefore corrupt a known location. It then writes bytes and halfwords with junk in the unused upper bits and reads the surrounding words. A wrong strobe or an unshifted write would overwrite a neighbouring lane. Misaligned and 2'b11 requests are followed by word reads, which expose a design that lets a refused access write. Accesses at the last legal starts and just past the window catch a range check that is off by one. They also catch a design that refuses a wrapped access instead of masking it.

// File: rtl/laneMemPkg.sv
package laneMemPkg;
  localparam int LANES = 4;
  localparam int DATA_W = 8 * LANES;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_BAD  = 2'b11
  } accSize_e;

  // strobes from control to datapath for the current request
  typedef struct packed {
    logic             wrEn;
    logic [LANES-1:0] laneMask;
    logic [1:0]       laneOff;
  } wrStrobe_t;

  // registered lane selection applied to the fetched word
  typedef struct packed {
    logic       rdOk;
    logic [1:0] laneOff;
    accSize_e   size;
  } rdSel_t;
endpackage

// File: rtl/laneMemCtrl.sv
module laneMemCtrl
  import laneMemPkg::*;
#(
  parameter int HIGH_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        addrLow,
  input  logic [HIGH_W-1:0] addrHigh,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  output wrStrobe_t         wrStb,
  output rdSel_t            rdSel,
  output logic              rspValid,
  output logic              rspErr
);
  accSize_e size;
  logic sizeBad, misAlign, outRange, reject;
  logic [LANES-1:0] mask;

  assign size     = accSize_e'(reqSize);
  assign sizeBad  = (size == SZ_BAD);
  assign misAlign = ((size == SZ_HALF) && addrLow[0]) ||
                    ((size == SZ_WORD) && (addrLow != 2'b00));
  assign outRange = |addrHigh;
  assign reject   = sizeBad || misAlign;

  always_comb begin
    case (size)
      SZ_BYTE: mask = 4'b0001 << addrLow;
      SZ_HALF: mask = 4'b0011 << addrLow;
      SZ_WORD: mask = 4'b1111;
      default: mask = 4'b0000;
    endcase
  end

  assign wrStb.wrEn     = reqValid && reqWrite && !reject;
  assign wrStb.laneMask = mask;
  assign wrStb.laneOff  = addrLow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      rdSel    <= '0;
    end else begin
      rspValid      <= reqValid;
      rspErr        <= reqValid && (reject || outRange);
      rdSel.rdOk    <= reqValid && !reqWrite && !reject;
      rdSel.laneOff <= addrLow;
      rdSel.size    <= size;
    end
  end
endmodule

// File: rtl/laneMemData.sv
module laneMemData
  import laneMemPkg::*;
#(
  parameter int WORD_W = 11
) (
  input  logic              clk,
  input  logic [WORD_W-1:0] wordIdx,
  input  wrStrobe_t         wrStb,
  input  logic [DATA_W-1:0] wdata,
  input  rdSel_t            rdSel,
  output logic [DATA_W-1:0] rdata
);
  localparam int WORDS = 1 << WORD_W;

  logic [DATA_W-1:0] mem [WORDS];
  logic [DATA_W-1:0] laneData, rdWord, shifted;

  assign laneData = wdata << {wrStb.laneOff, 3'b000};

  always_ff @(posedge clk) begin
    for (int ln = 0; ln < LANES; ln++) begin
      if (wrStb.wrEn && wrStb.laneMask[ln])
        mem[wordIdx][8*ln +: 8] <= laneData[8*ln +: 8];
    end
    rdWord <= mem[wordIdx];
  end

  assign shifted = rdWord >> {rdSel.laneOff, 3'b000};

  always_comb begin
    rdata = '0;
    if (rdSel.rdOk) begin
      case (rdSel.size)
        SZ_BYTE: rdata[7:0]  = shifted[7:0];
        SZ_HALF: rdata[15:0] = shifted[15:0];
        SZ_WORD: rdata       = shifted;
        default: rdata       = '0;
      endcase
    end
  end
endmodule

// File: rtl/laneMemAdapter.sv
module laneMemAdapter
  import laneMemPkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int MEM_BYTES = 8192
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  input  logic [31:0]       reqWdata,
  output logic              rspValid,
  output logic [31:0]       rspRdata,
  output logic              rspErr
);
  localparam int OFFS_W = $clog2(MEM_BYTES);
  localparam int WORD_W = OFFS_W - 2;
  localparam int HIGH_W = ADDR_W - OFFS_W;

  wrStrobe_t wrStb;
  rdSel_t    rdSel;

  laneMemCtrl #(.HIGH_W(HIGH_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .addrLow(reqAddr[1:0]), .addrHigh(reqAddr[ADDR_W-1:OFFS_W]),
    .reqSize(reqSize), .reqWrite(reqWrite),
    .wrStb(wrStb), .rdSel(rdSel), .rspValid(rspValid), .rspErr(rspErr)
  );

  laneMemData #(.WORD_W(WORD_W)) i_data (
    .clk(clk), .wordIdx(reqAddr[OFFS_W-1:2]), .wrStb(wrStb),
    .wdata(reqWdata), .rdSel(rdSel), .rdata(rspRdata)
  );
endmodule

// File: rtl/laneMemAdapterChk.sv
module laneMemAdapterChk #(
  parameter int HIGH_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [1:0]        addrLow,
  input logic [HIGH_W-1:0] addrHigh,
  input logic [1:0]        reqSize,
  input logic              rspValid,
  input logic [31:0]       rspRdata,
  input logic              rspErr
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN) reqValid |=> rspValid); // R4
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rstN) !reqValid |=> !rspValid); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN) !rspValid |-> (rspRdata == 32'd0 && !rspErr)); // R4
  AST_BAD_SIZE_ERR: assert property (@(posedge clk) disable iff (!rstN) (reqValid && reqSize == 2'b11) |=> (rspErr && rspRdata == 32'd0)); // R5
  AST_MISALIGN_ERR: assert property (@(posedge clk) disable iff (!rstN) (reqValid && ((reqSize == 2'b01 && addrLow[0]) || (reqSize == 2'b10 && addrLow != 2'b00))) |=> (rspErr && rspRdata == 32'd0)); // R6
  AST_RANGE_ERR: assert property (@(posedge clk) disable iff (!rstN) (reqValid && addrHigh != '0) |=> rspErr); // R8
  AST_LEGAL_NO_ERR: assert property (@(posedge clk) disable iff (!rstN) (reqValid && addrHigh == '0 && (reqSize == 2'b00 || (reqSize == 2'b01 && !addrLow[0]) || (reqSize == 2'b10 && addrLow == 2'b00))) |=> !rspErr); // R7
  AST_BYTE_ZERO_EXT: assert property (@(posedge clk) disable iff (!rstN) (reqValid && reqSize == 2'b00) |=> (rspRdata[31:8] == 24'd0)); // R3
  AST_HALF_ZERO_EXT: assert property (@(posedge clk) disable iff (!rstN) (reqValid && reqSize == 2'b01) |=> (rspRdata[31:16] == 16'd0)); // R3
endmodule

bind laneMemAdapter laneMemAdapterChk #(.HIGH_W(HIGH_W)) i_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid),
  .addrLow(reqAddr[1:0]), .addrHigh(reqAddr[ADDR_W-1:OFFS_W]),
  .reqSize(reqSize), .rspValid(rspValid), .rspRdata(rspRdata), .rspErr(rspErr)
);

// File: tb/test_laneMemAdapter.sv
`timescale 1ns/1ps
module test_laneMemAdapter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqWdata = '0;
  logic        rspValid;
  logic [31:0] rspRdata;
  logic        rspErr;

  int total = 0;
  int failed = 0;
  logic [7:0] model [0:8191];

  always #10 clk = ~clk;

  laneMemAdapter i_laneMemAdapter (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata), .rspErr(rspErr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int w);
    return (w * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  task automatic access(input logic [15:0] a, input logic [1:0] sz, input logic wr,
                        input logic [31:0] wd, input string tag);
    logic [12:0] o;
    logic rej, expErr;
    logic [31:0] expData;
    int n;
    o = a[12:0];
    rej = (sz == 2'b11) || (sz == 2'b01 && a[0]) || (sz == 2'b10 && a[1:0] != 2'b00);
    expErr = rej || (a[15:13] != 3'b000);
    n = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    expData = '0;
    if (!rej) begin
      for (int k = 0; k < n; k++) begin
        if (wr) model[o + 13'(k)] = wd[8*k +: 8];
        else expData[8*k +: 8] = model[o + 13'(k)];
      end
    end
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqSize = sz; reqWrite = wr; reqWdata = wd;
    @(negedge clk);
    check({tag, " rspValid"}, {31'd0, rspValid}, 32'd1);
    check({tag, " rspErr"}, {31'd0, rspErr}, {31'd0, expErr});
    check({tag, " rspRdata"}, rspRdata, expData);
    reqValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failed++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 rspValid", {31'd0, rspValid}, 32'd0);
    check("R9 rspErr", {31'd0, rspErr}, 32'd0);
    check("R9 rspRdata", rspRdata, 32'd0);
    rstN = 1'b1;

    // R1: fill every word, then read back as words, halfwords and bytes
    for (int w = 0; w < 2048; w++) access(16'(w * 4), 2'b10, 1'b1, pat(w), "R1 fill");
    for (int w = 0; w < 2048; w++) access(16'(w * 4), 2'b10, 1'b0, 0, "R1 word read");
    for (int h = 0; h < 4096; h++) access(16'(h * 2), 2'b01, 1'b0, 0, "R3 half read");
    for (int b = 0; b < 8192; b++) access(16'(b), 2'b00, 1'b0, 0, "R3 byte read");

    // R2: partial writes with junk above the access size
    for (int b = 0; b < 128; b++)
      access(16'(b), 2'b00, 1'b1, {24'hDEADBE, 8'(b) ^ 8'hA5}, "R2 byte write");
    for (int h = 0; h < 64; h++)
      access(16'(256 + h * 2), 2'b01, 1'b1, {16'hBEEF, 16'(h * 16'h1357)}, "R2 half write");
    for (int w = 0; w < 96; w++) access(16'(w * 4), 2'b10, 1'b0, 0, "R2 word check");

    // R6: misaligned requests are refused and write nothing
    for (int a = 16'h400; a < 16'h410; a++) begin
      if (a[0]) access(16'(a), 2'b01, 1'b1, 32'hFFFFFFFF, "R6 half misaligned");
      if (a[1:0] != 2'b00) access(16'(a), 2'b10, 1'b1, 32'h00000000, "R6 word misaligned");
      if (a[1:0] != 2'b00) access(16'(a), 2'b10, 1'b0, 0, "R6 word misaligned read");
    end
    for (int w = 16'h100; w < 16'h104; w++) access(16'(w * 4), 2'b10, 1'b0, 0, "R6 unchanged");

    // R5: size code 2'b11
    for (int a = 16'h500; a < 16'h504; a++) begin
      access(16'(a), 2'b11, 1'b1, 32'h12345678, "R5 bad size write");
      access(16'(a), 2'b11, 1'b0, 0, "R5 bad size read");
    end
    access(16'h500, 2'b10, 1'b0, 0, "R5 unchanged");

    // R7: last legal start addresses
    access(16'h1FFF, 2'b00, 1'b1, 32'hFFFFFF77, "R7 last byte write");
    access(16'h1FFF, 2'b00, 1'b0, 0, "R7 last byte read");
    access(16'h1FFE, 2'b01, 1'b1, 32'hFFFF6655, "R7 last half write");
    access(16'h1FFE, 2'b01, 1'b0, 0, "R7 last half read");
    access(16'h1FFC, 2'b10, 1'b0, 0, "R7 last word read");
    access(16'h1FFF, 2'b01, 1'b0, 0, "R6 half at 0x1FFF");

    // R8: wrap by masking, with the error flag raised
    access(16'h2000, 2'b10, 1'b1, 32'hCAFEF00D, "R8 wrap write");
    access(16'h0000, 2'b10, 1'b0, 0, "R8 wrapped target");
    access(16'hE004, 2'b01, 1'b0, 0, "R8 wrap half read");
    access(16'hFFFF, 2'b00, 1'b0, 0, "R8 wrap byte read");
    access(16'h2001, 2'b01, 1'b1, 32'h0, "R8 wrap misaligned");
    access(16'h0000, 2'b10, 1'b0, 0, "R8 after misaligned");

    // R4: no request means no response
    @(negedge clk);
    check("R4 idle rspValid", {31'd0, rspValid}, 32'd0);
    check("R4 idle rspErr", {31'd0, rspErr}, 32'd0);
    check("R4 idle rspRdata", rspRdata, 32'd0);
    access(16'h0010, 2'b10, 1'b1, 32'h44332211, "R4 write rdata zero");
    access(16'h0012, 2'b00, 1'b0, 0, "R1 little endian lane 2");

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule